// File: doc/BRIEF.md
# Split-Flag Overflow Timer

An 8-bit up-counter advanced by one of four free-running enable pulses. A one-byte control/status register holds the enable-pulse select, a counter clear select, a capture-edge select and an overflow interrupt enable. Its top two bits are sticky overflow flags. When the counter wraps from 0xFF to 0x00, the level of the capture input decides which flag is set. In interval mode, every wrap sets the same flag.

Software reaches the block through a byte-wide port. Address 0 is the control/status register and address 1 is the counter. A flag cannot be set from the bus. To clear a flag, software must first read it as 1 and then write 0 to it. The capture input is synchronized inside the block. Its synchronized edges can zero the counter and raise a capture interrupt pulse.

Top module: `ovf_split_timer`

## Requirements
- R1: After reset, the control/status register reads 0x00, the counter reads 0x00, and both interrupt outputs are low.
- R2: The counter steps by one on each cycle in which the enable pulse selected by bits 1:0 is high. Value 0..3 selects tick_src[0..3], and the other pulses have no effect on the counter.
- R3: When the counter wraps from 0xFF to 0x00 while the synchronized capture level is high and interval mode is off, bit 7 (high-level overflow flag) is set.
- R4: When the counter wraps while the synchronized capture level is low, or on any wrap in interval mode, bit 6 (low-level overflow flag) is set. In interval mode bit 7 is not set.
- R5: Writing 1 to bit 7 or bit 6 never sets that flag.
- R6: Writing 0 to a flag clears it only if a read of address 0 returned that flag as 1 since the last write to address 0. Any write to address 0 disarms both flags.
- R7: If a wrap that sets a flag happens in the same cycle as a valid clearing write to that flag, the flag ends up 1.
- R8: Bits 5:0 are plain read/write bits. Bit 5 is the overflow interrupt enable, bit 4 is the capture-edge select, bits 3:2 are the clear select, and bits 1:0 are the enable-pulse select.
- R9: ovf_irq equals bit 5 AND (bit 7 OR bit 6).
- R10: cap_in passes through two flops before it is used. The clear select zeroes the counter on synchronized capture edges: 00 never, 01 on rising edges, 10 on falling edges, 11 on both. A clear takes precedence over a step, and a clear never causes a wrap.
- R11: cap_irq pulses high for one cycle on a synchronized rising edge when bit 4 is 1, or on a falling edge when bit 4 is 0.
- R12: A write to address 1 loads the counter. The load takes precedence over clear and step, and it never causes a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; arms flag clearing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tick_src | input | 4 | Four prescaled enable pulses |
| cap_in | input | 1 | Asynchronous capture input |
| interval_mode | input | 1 | Interval mode: every wrap sets bit 6 |
| ovf_irq | output | 1 | Overflow interrupt request |
| cap_irq | output | 1 | Capture-edge interrupt pulse |

## Verification
Wraps are driven with the capture level held high, held low, and in interval mode. This tells apart a flag chosen by the synchronized level from a flag chosen by the raw pin or picked at random. Clear attempts are made without a prior read, after a read, and in the same cycle as a wrap. These separate the arming rule and the set-over-clear priority from a plain write-0 clear. Random traffic mixes enable pulses, capture toggles, loads and mode writes, and it is compared cycle by cycle with a reference model. This exposes errors in pulse selection, edge-clear selection and load priority.

// File: rtl/ovf_split_timer.sv
module ovf_split_timer #(
  parameter int CW = 8,
  parameter int NSRC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [NSRC-1:0] tick_src,
  input  logic          cap_in,
  input  logic          interval_mode,
  output logic          ovf_irq,
  output logic          cap_irq
);
  localparam int SW = $clog2(NSRC);

  logic [CW-1:0] cnt;
  logic [5:0]    ctl;
  logic          flg_h, flg_l, arm_h, arm_l;
  logic          s1, s2, s3;

  wire [SW-1:0] sel    = ctl[SW-1:0];
  wire [1:0]    cclr   = ctl[3:2];
  wire          iegs   = ctl[4];
  wire          ovie   = ctl[5];
  wire          wr_ctl = bus_wr && !bus_addr;
  wire          wr_cnt = bus_wr && bus_addr;
  wire          rd_ctl = bus_rd && !bus_addr;
  wire          rise   = s2 && !s3;
  wire          fall   = !s2 && s3;
  wire          clr    = (cclr[0] && rise) || (cclr[1] && fall);
  wire          step   = tick_src[sel];
  wire          wrap   = step && (cnt == {CW{1'b1}}) && !wr_cnt && !clr;
  wire          set_h  = wrap && s2 && !interval_mode;
  wire          set_l  = wrap && (!s2 || interval_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= bus_wdata[CW-1:0];
    else if (clr)    cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl <= '0;
    else if (wr_ctl) ctl <= bus_wdata[5:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_h <= 1'b0; flg_l <= 1'b0; arm_h <= 1'b0; arm_l <= 1'b0;
    end else begin
      if (set_h)                                  flg_h <= 1'b1;
      else if (wr_ctl && !bus_wdata[7] && arm_h)  flg_h <= 1'b0;
      if (set_l)                                  flg_l <= 1'b1;
      else if (wr_ctl && !bus_wdata[6] && arm_l)  flg_l <= 1'b0;
      if (wr_ctl) begin
        arm_h <= 1'b0; arm_l <= 1'b0;
      end else if (rd_ctl) begin
        if (flg_h) arm_h <= 1'b1;
        if (flg_l) arm_l <= 1'b1;
      end
    end
  end

  assign bus_rdata = bus_addr ? 8'(cnt) : {flg_h, flg_l, ctl};
  assign ovf_irq   = ovie && (flg_h || flg_l);
  assign cap_irq   = iegs ? rise : fall;

  AST_H_RISE_NEEDS_HIGH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_h) |-> $past(s2 && !interval_mode && cnt == {CW{1'b1}})); // R3
  AST_INTERVAL_KEEPS_H: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_mode && !wr_ctl && !flg_h) |=> !flg_h); // R4
  AST_FALL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg_l) |-> $past(arm_l && wr_ctl)); // R6
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !flg_h && !wrap) |=> !flg_h); // R5
  AST_IDLE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !clr && !step) |=> $stable(cnt)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == $past(bus_wdata[CW-1:0]))); // R12
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (flg_h || flg_l)); // R7
  AST_CAP_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |=> !cap_irq || $changed(s2)); // R11
endmodule

// File: tb/sim_ovf_split_timer.sv
module sim_ovf_split_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0, cap = 1'b0, imode = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [3:0] tick = 4'h0;
  logic [7:0] rdata;
  logic oirq, cirq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ovf_split_timer u0 (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .tick_src(tick),
    .cap_in(cap), .interval_mode(imode), .ovf_irq(oirq), .cap_irq(cirq));

  logic m1, m2, m3, mh, ml, mah, mal;
  logic [7:0] mcnt;
  logic [5:0] mctl;

  always @(posedge clk) begin
    logic rise, fall, clr, tk, wrc, wrm, wrp, sh, sl;
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; mh = 0; ml = 0; mah = 0; mal = 0;
      mcnt = 0; mctl = 0;
    end else begin
      rise = m2 && !m3; fall = !m2 && m3;
      clr = (mctl[2] && rise) || (mctl[3] && fall);
      tk = tick[mctl[1:0]];
      wrc = wr && addr; wrm = wr && !addr;
      wrp = !wrc && !clr && tk && mcnt == 8'hFF;
      sh = wrp && m2 && !imode;
      sl = wrp && (!m2 || imode);
      if (wrm) begin mah = 0; mal = 0; end
      else if (rd && !addr) begin
        if (mh) mah = 1;
        if (ml) mal = 1;
      end
      // arm update above uses old flags; clear below uses old arm
      if (sh) mh = 1; else if (wrm && !wdata[7] && u_arm_h_old) mh = 0;
      if (sl) ml = 1; else if (wrm && !wdata[6] && u_arm_l_old) ml = 0;
      if (wrc) mcnt = wdata; else if (clr) mcnt = 0; else if (tk) mcnt = mcnt + 1;
      if (wrm) mctl = wdata[5:0];
      m3 = m2; m2 = m1; m1 = cap;
    end
    u_arm_h_old = mah; u_arm_l_old = mal;
  end
  logic u_arm_h_old = 0, u_arm_l_old = 0;

  function automatic logic [7:0] exp_rdata();
    return addr ? mcnt : {mh, ml, mctl};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(addr ? "R2" : "R8", rdata, exp_rdata());
    chk("R9", {7'b0, oirq}, {7'b0, mctl[5] && (mh || ml)});
    chk("R11", {7'b0, cirq}, {7'b0, mctl[4] ? (m2 && !m3) : (!m2 && m3)});
  endtask

  task automatic cyc(input logic a, input logic w, input logic r, input logic [7:0] d);
    addr = a; wr = w; rd = r; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 0; rd = 0;
    cmp_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(addr, 0, 0, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    void'($urandom(32'd7081));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    addr = 0;
    chk("R1", rdata, 8'h00);
    chk("R1", {7'b0, oirq}, 8'h00);
    addr = 1; #1 chk("R1", rdata, 8'h00);
    // R3: high-level wrap
    cap = 1; idle(3);
    cyc(0, 1, 0, 8'h20);
    cyc(1, 1, 0, 8'hFE);
    tick = 4'b0001; idle(2); tick = 0;
    cyc(0, 0, 0, 0);
    chk("R3", rdata, 8'hA0);
    chk("R9", {7'b0, oirq}, 8'h01);
    // R6: unarmed writes of 0 do nothing
    cyc(0, 1, 0, 8'h20); chk("R6", rdata, 8'hA0);
    cyc(0, 1, 1, 8'h20); chk("R6", rdata, 8'hA0);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 8'h20); chk("R6", rdata, 8'h20);
    // R5: writing ones sets nothing
    cyc(0, 1, 0, 8'hC0); chk("R5", rdata, 8'h00);
    // R4: interval mode, capture high
    imode = 1;
    cyc(1, 1, 0, 8'hFF);
    tick = 4'b0001; cyc(0, 0, 0, 0); tick = 0;
    chk("R4", rdata, 8'h40);
    // R7: clearing write coincides with wrap
    cyc(1, 1, 0, 8'hFF);
    cyc(0, 0, 1, 0);
    tick = 4'b0001; cyc(0, 1, 0, 8'h00); tick = 0;
    chk("R7", rdata, 8'h40);
    imode = 0;
    // R10: rising-edge clear, seen only after synchronizer
    cap = 0; idle(3);
    cyc(0, 1, 0, 8'h14);
    cyc(1, 1, 0, 8'h33);
    cap = 1; cyc(1, 0, 0, 0);
    chk("R10", rdata, 8'h33);
    idle(3);
    chk("R10", rdata, 8'h00);
    // R12: load beats a step
    tick = 4'b1111; cyc(1, 1, 0, 8'h55); tick = 0;
    chk("R12", rdata, 8'h55);
    // R2: unselected pulse ignored, selected one steps
    cyc(0, 1, 0, 8'h02);
    tick = 4'b1011; cyc(1, 0, 0, 0); chk("R2", rdata, 8'h55);
    tick = 4'b0100; cyc(1, 0, 0, 0); chk("R2", rdata, 8'h56);
    tick = 0;
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r = $urandom;
      tick = r[3:0];
      if (r[11:8] == 0) cap = ~cap;
      imode = (r[15:12] == 0) ? ~imode : imode;
      case (r[18:16])
        3'd0: cyc(0, 1, r[19], {r[23:20], r[25:24], r[27:26]});
        3'd1: cyc(1, 1, 0, {6'h3F, r[21:20]});
        3'd2, 3'd3: cyc(0, 0, 1, 0);
        default: cyc(r[28], 0, 0, 0);
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule